// File: doc/BRIEF.md
# Running-Disparity Word Inversion Encoder

This block encodes one lane of a DC-balanced serial link. Each parallel cycle in which the input is valid, it accepts a 7-bit data group and emits a 9-bit word. The word is made of two complementary flag bits followed by the group, which is sent either as it is or bitwise inverted. A signed running sum tracks the balance of transmitted ones and zeros. Each one adds +1 and each zero adds -1. The choice to invert is made at every word boundary from the sign of that sum and the disparity of the incoming group. This keeps the line free of a long-term DC component, so the link can be AC-coupled.

A receiver restores the group by looking at the first flag bit. The flag pair always carries one 1 and one 0, so it never moves the sum. A mode input selects balanced operation. While that input is low, every group is passed through uninverted and the sum is held at zero, so each entry into balanced mode starts from a clean zero. Serialization of the word and clock generation belong to the surrounding logic.

Top module: `rdenc_top`

## Requirements
- R1: A group accepted with `inValid` high appears one clock later with `outValid` high. The word layout is: bit 8 is flag A, bit 7 is flag B, bits 6:0 are the group (true or inverted, group bit 6 in word bit 6). The word goes onto the line starting at bit 8 and ending at bit 0. Inverting bits 6:0 again when flag A is 1 recovers the accepted group.
- R2: The flags are always complementary. A=1, B=0 marks an inverted group and A=0, B=1 marks a true group.
- R3: After each accepted group in balanced mode, `outSum` equals its previous value plus (ones minus zeros) of the 7 transmitted data bits. The flags add nothing.
- R4: In balanced mode, `outSum` at every word boundary lies within -7..+7. The bit-serial running sum taken over the transmitted stream never exceeds 10 in magnitude.
- R5: In balanced mode, the group is inverted exactly when the sum is positive and the group has more ones than zeros, or when the sum is negative and the group has more zeros than ones. When the sum is zero, the group is sent true.
- R6: While `balEn` is low, no group is inverted (flags 01) and `outSum` is held at 0. The first balanced group after re-entry is therefore encoded from a sum of zero.
- R7: A cycle with `inValid` low gives `outValid` low on the next clock. In balanced mode it leaves `outSum` unchanged.
- R8: During and directly after reset, `outValid` is 0, `outWord` is 0 and `outSum` is 0.

Further rule (part of R5): with the default odd group width a group never has zero disparity. Should a width with zero disparity be chosen, such a group is sent true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock, one group per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| balEn | input | 1 | 1 selects balanced encoding, 0 passes groups through with the sum held at zero |
| inValid | input | 1 | Group on `inData` is to be encoded this cycle |
| inData | input | DATA_W (7) | Parallel data group |
| outValid | output | 1 | `outWord` carries a new word this cycle |
| outWord | output | DATA_W+2 (9) | Flag A, flag B, then the transmitted group |
| outSum | output | SUM_W (5) | Signed running sum after the word on `outWord` |

## Verification
The bench drives saturating streams of all-ones and all-zeros groups. A design that inverted on the wrong sign, or counted the flags into the sum, would let the word-boundary sum run past 7 and drift without limit. It then pushes the sum to +7 and -7 and follows with groups whose leading bits run the same way (1110000 and 0001111). These put the bit-serial sum at exactly ±10, so a wrong tie rule or a wrong transmission order goes past the bound. Mode toggles with idle gaps check that the sum is cleared on re-entry and held across empty cycles, and long random streams compare each word, its decoded data and the sum against an independent model.

// File: rtl/rdenc_pkg.sv
package rdenc_pkg;

  // sign class of the running sum, seen by the control logic
  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } sumSgn_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new word this cycle
    logic invert;  // send the group complemented
    logic clear;   // force the running sum to zero
  } encStrobe_t;

endpackage

// File: rtl/rdenc_ctrl.sv
module rdenc_ctrl
  import rdenc_pkg::*;
(
  input  logic       inValid,
  input  logic       balEn,
  input  sumSgn_t    sumSgn,
  input  logic       dispPos,
  input  logic       dispNeg,
  output encStrobe_t strb
);

  logic pullDown;
  logic pullUp;

  // invert when the group would push the sum further from zero
  assign pullDown = (sumSgn == SGN_POS) && dispPos;
  assign pullUp   = (sumSgn == SGN_NEG) && dispNeg;

  always_comb begin
    strb        = '0;
    strb.load   = inValid;
    strb.clear  = !balEn;
    strb.invert = balEn && (pullDown || pullUp);
  end

endmodule

// File: rtl/rdenc_datapath.sv
module rdenc_datapath
  import rdenc_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  encStrobe_t               strb,
  input  logic [DATA_W-1:0]        inData,
  output logic                     dispPos,
  output logic                     dispNeg,
  output sumSgn_t                  sumSgn,
  output logic                     outValid,
  output logic [DATA_W+1:0]        outWord,
  output logic signed [SUM_W-1:0]  outSum
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int WORD_W = DATA_W + 2;

  // ripple population count over the group
  logic [CNT_W-1:0] partial [DATA_W+1];
  assign partial[0] = '0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_pop
    assign partial[i+1] = partial[i] + CNT_W'(inData[i]);
  end

  logic signed [SUM_W-1:0] dispRaw;
  logic signed [SUM_W-1:0] step;
  logic signed [SUM_W-1:0] sumQ;
  logic signed [SUM_W-1:0] sumNext;
  logic [WORD_W-1:0]       wordQ;
  logic [WORD_W-1:0]       wordNext;
  logic                    validQ;

  // disparity = ones - zeros = 2*ones - width
  assign dispRaw = $signed(SUM_W'({partial[DATA_W], 1'b0})) - $signed(SUM_W'(DATA_W));
  assign dispPos = dispRaw > $signed(SUM_W'(0));
  assign dispNeg = dispRaw < $signed(SUM_W'(0));

  always_comb begin
    if (sumQ > $signed(SUM_W'(0)))      sumSgn = SGN_POS;
    else if (sumQ < $signed(SUM_W'(0))) sumSgn = SGN_NEG;
    else                                sumSgn = SGN_ZERO;
  end

  always_comb begin
    step     = strb.invert ? -dispRaw : dispRaw;
    wordNext = {strb.invert, !strb.invert, (strb.invert ? ~inData : inData)};
    if (strb.clear)     sumNext = '0;
    else if (strb.load) sumNext = sumQ + step;
    else                sumNext = sumQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ   <= '0;
      wordQ  <= '0;
      validQ <= 1'b0;
    end else begin
      sumQ   <= sumNext;
      validQ <= strb.load;
      if (strb.load) wordQ <= wordNext;
    end
  end

  assign outValid = validQ;
  assign outWord  = wordQ;
  assign outSum   = sumQ;

endmodule

// File: rtl/rdenc_top.sv
module rdenc_top
  import rdenc_pkg::*;
#(
  parameter  int DATA_W = 7,
  localparam int SUM_W  = $clog2(DATA_W + 1) + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     balEn,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        inData,
  output logic                     outValid,
  output logic [DATA_W+1:0]        outWord,
  output logic signed [SUM_W-1:0]  outSum
);

  encStrobe_t strb;
  sumSgn_t    sumSgn;
  logic       dispPos;
  logic       dispNeg;

  rdenc_ctrl u_ctrl (
    .inValid (inValid),
    .balEn   (balEn),
    .sumSgn  (sumSgn),
    .dispPos (dispPos),
    .dispNeg (dispNeg),
    .strb    (strb)
  );

  rdenc_datapath #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inData   (inData),
    .dispPos  (dispPos),
    .dispNeg  (dispNeg),
    .sumSgn   (sumSgn),
    .outValid (outValid),
    .outWord  (outWord),
    .outSum   (outSum)
  );

endmodule

// File: rtl/rdenc_checker.sv
module rdenc_checker #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    balEn,
  input logic                    inValid,
  input logic [DATA_W-1:0]       inData,
  input logic                    outValid,
  input logic [DATA_W+1:0]       outWord,
  input logic signed [SUM_W-1:0] outSum
);

  localparam int FA = DATA_W + 1;
  localparam int FB = DATA_W;

  int sentDisp;
  int inDisp;
  assign sentDisp = 2 * $countones(outWord[DATA_W-1:0]) - DATA_W;
  assign inDisp   = 2 * $countones(inData) - DATA_W;

  // R1: accepted group shows up one clock later and decodes back
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_recover_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((outWord[FA] ? ~outWord[DATA_W-1:0] : outWord[DATA_W-1:0]) == $past(inData)));

  // R2: flag pair always complementary
  p_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWord[FA] != outWord[FB]));

  // R3: sum moves by the disparity of the transmitted data bits
  p_sum_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (balEn && inValid) |=> (int'(outSum) == int'($past(outSum)) + sentDisp));

  // R4: word-boundary sum bounded
  p_sum_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(outSum) <= DATA_W) && (int'(outSum) >= -DATA_W));

  // R5: inversion rule
  p_inv_pos_r5: assert property (@(posedge clk) disable iff (!rstN)
    (balEn && inValid && outSum > 0 && inDisp > 0) |=> outWord[FA]);
  p_inv_neg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (balEn && inValid && outSum < 0 && inDisp < 0) |=> outWord[FA]);
  p_true_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (balEn && inValid && outSum == 0) |=> !outWord[FA]);

  // R6: pass-through mode
  p_off_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    !balEn |=> (outSum == 0));
  p_off_true_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!balEn && inValid) |=> (!outWord[FA] && outWord[FB]));

  // R7: idle cycles
  p_idle_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (balEn && !inValid) |=> $stable(outSum));

  // R8: reset state
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_r8: assert (!outValid && outWord == '0 && outSum == 0);
    end
  end

endmodule

bind rdenc_top rdenc_checker #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .balEn    (balEn),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outWord  (outWord),
  .outSum   (outSum)
);

// File: tb/rdenc_top_tb.sv
module rdenc_top_tb;

  localparam int DW = 7;
  localparam int SW = 5;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           balEn = 1'b1;
  logic           inValid = 1'b0;
  logic [DW-1:0]  inData = '0;
  logic           outValid;
  logic [DW+1:0]  outWord;
  logic signed [SW-1:0] outSum;

  always #10 clk = ~clk;  // 50 MHz

  rdenc_top #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .balEn(balEn), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outWord(outWord), .outSum(outSum)
  );

  typedef struct packed {
    logic [DW+1:0]      word;
    logic signed [31:0] sum;
    logic               bal;
    logic [DW-1:0]      data;
  } item_t;

  item_t expQ [$];
  int    nChecks = 0;
  int    nFails  = 0;
  int    mSum    = 0;   // model word-boundary sum
  int    bitSum  = 0;   // bit-serial running sum seen by monitor
  int    peakAbs = 0;
  bit    done    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: encode with an independent model and push the expectation
  task automatic send(input logic [DW-1:0] d, input bit bal);
    item_t it;
    int    disp;
    bit    inv;
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    balEn   = bal;
    disp    = 2 * $countones(d) - DW;
    if (bal) begin
      inv  = (mSum > 0 && disp > 0) || (mSum < 0 && disp < 0);
      mSum = mSum + (inv ? -disp : disp);
    end else begin
      inv  = 1'b0;
      mSum = 0;
    end
    it.word = {inv, !inv, (inv ? ~d : d)};
    it.sum  = mSum;
    it.bal  = bal;
    it.data = d;
    expQ.push_back(it);
  endtask

  // idle cycles, R7: no word, sum unchanged (zero when not balanced)
  task automatic idle(input int n, input bit bal);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(outValid == 1'b0, "R7", "outValid during idle", outValid, 0);
        chk(int'(outSum) == mSum, bal ? "R7" : "R6", "sum during idle", outSum, mSum);
      end
      inValid = 1'b0;
      balEn   = bal;
      if (!bal) mSum = 0;
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7", "unexpected word", outWord, 0);
      end else begin
        item_t e;
        logic [DW-1:0] dec;
        e = expQ.pop_front();
        chk(outWord == e.word, "R5", "word", outWord, e.word);
        chk(outWord[DW+1] != outWord[DW], "R2", "flag pair", outWord[DW+1:DW], e.word[DW+1:DW]);
        dec = outWord[DW+1] ? ~outWord[DW-1:0] : outWord[DW-1:0];
        chk(dec == e.data, "R1", "decoded data", dec, e.data);
        chk(int'(outSum) == e.sum, e.bal ? "R3" : "R6", "running sum", outSum, e.sum);
        if (e.bal) begin
          for (int b = DW + 1; b >= 0; b--) begin
            bitSum += outWord[b] ? 1 : -1;
            if (bitSum > peakAbs)  peakAbs = bitSum;
            if (-bitSum > peakAbs) peakAbs = -bitSum;
            if (bitSum > 10 || bitSum < -10)
              chk(1'b0, "R4", "bit-serial sum", bitSum, 10);
          end
          chk(int'(outSum) <= DW && int'(outSum) >= -DW, "R4", "boundary sum", outSum, DW);
        end else begin
          bitSum = 0;
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(outValid == 1'b0, "R8", "outValid in reset", outValid, 0);
    chk(outWord == '0, "R8", "outWord in reset", outWord, 0);
    chk(outSum == 0, "R8", "outSum in reset", outSum, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && outSum == 0, "R8", "after release", outSum, 0);

    // R5 zero-sum tie: first group sent true
    send(7'h7F, 1'b1);
    // R4 upper edge: sum +7 then ones-first group gives bit peak 10
    send(7'b1110000, 1'b1);
    send(7'h7F, 1'b1);
    send(7'h7F, 1'b1);
    idle(3, 1'b1);

    // R6: leave balanced mode, pass-through and clear
    for (int i = 0; i < 6; i++) send(7'h7F, 1'b0);
    idle(2, 1'b0);
    // lower edge: sum -7 then zeros-first group
    send(7'h00, 1'b1);
    send(7'b0001111, 1'b1);
    // saturating streams
    for (int i = 0; i < 60; i++) send(7'h7F, 1'b1);
    for (int i = 0; i < 60; i++) send(7'h00, 1'b1);
    for (int i = 0; i < 40; i++) send((i % 2) ? 7'h00 : 7'h7F, 1'b1);
    for (int i = 0; i < 40; i++) send(7'b1010101, 1'b1);
    idle(4, 1'b1);

    // random stream with idle gaps and occasional mode drops
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8)       idle(2, 1'b1);
      else if (r < 10) send(7'($urandom), 1'b0);
      else             send(7'($urandom), 1'b1);
    end
    idle(4, 1'b1);
    chk(expQ.size() == 0, "R1", "words left unmatched", expQ.size(), 0);
    chk(peakAbs == 10, "R4", "bit-serial peak reached", peakAbs, 10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule